// File: doc/BRIEF.md
# Serial-Input Parity Checker Receiver

This block takes asynchronous serial frames from one input wire and turns each into a parallel byte. The line rests high. A frame is one low start bit, then the data bits, least significant first, then one high stop bit. The block looks for a falling edge while it is not receiving. That edge starts two counters:

- a bit timer that repeats once per bit time and samples each data bit at the middle of its bit period;
- a frame timer that ends the reception after ten bit times.

When the frame timer ends, shifting stops. The assembled byte is copied into a hold register and stays there until the next frame completes.

Parity flags are formed over the held byte together with an external cascade bit. Several of these checkers can therefore be chained, with the parity of one stage feeding the cascade input of the next. An enable input gates both flags. While the enable is low, both flags read zero. While it is high, exactly one flag is set: the even flag when the nine bits hold an even number of ones, and the odd flag otherwise.

The received byte leaves the block as a valid-only stream: `rx_valid` pulses for one cycle when `rx_byte` takes a new value. There is no ready input, because a serial line cannot be held off. A consumer that needs the byte later reads it from `rx_byte`, which stays stable until the next pulse. The bit period is CLK_HZ/BAUD clock cycles, rounded down, and must be at least 4.

Top module: `serpar_parity_rx`

## Requirements
- R1: While reset is asserted and after reset is released, `rx_byte` is 0 and `rx_valid` is 0.
- R2: A frame on `line_in` (low start bit, DATA_W data bits least significant bit first, high stop bit, each one bit period long) yields that byte on `rx_byte`, with bit 0 being the first data bit after the start bit.
- R3: Each data bit is sampled at the middle of its bit period, where one bit period is CLK_HZ/BAUD clock cycles. A frame driven with exact bit timing is therefore received correctly for every byte value.
- R4: `rx_valid` is high for exactly one cycle per frame, when the frame timer expires (ten bit times after start detection), and never while the line is idle.
- R5: `rx_byte` holds its value at all times when `rx_valid` is not being raised. It is not disturbed by a frame in progress or by idle time.
- R6: With `par_en`=1, `par_even` is 1 exactly when the count of ones in {`casc_in`, `rx_byte`} is even.
- R7: With `par_en`=1, `par_odd` is the inverse of `par_even`, so exactly one of the two flags is high.
- R8: With `par_en`=0, `par_even` and `par_odd` are both 0, whatever the byte and cascade bit.
- R9: A start bit that begins immediately after a stop bit (back-to-back frames with no idle gap) is accepted, and both frames are delivered.
- R10: Falling edges on `line_in` inside a frame in progress (zero data bits) do not restart reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Serial data line, idles high |
| casc_in | input | 1 | Cascade bit folded into the parity |
| par_en | input | 1 | Enables the parity flags |
| rx_byte | output | DATA_W | Last received byte, held between frames |
| rx_valid | output | 1 | One-cycle pulse when rx_byte updates |
| par_even | output | 1 | Even parity over {casc_in, rx_byte}, gated by par_en |
| par_odd | output | 1 | Odd parity over {casc_in, rx_byte}, gated by par_en |

## Verification
Every one of the 256 byte values is sent back-to-back, each with its own cascade and enable setting.

- The full byte sweep tells a wrong bit order or an off-centre sample point apart from correct reception.
- The gapless spacing separates a receiver that rearms at the end of the frame window from one that drops the next start bit.
- The data values contain mid-frame falling edges, which expose a receiver that retriggers on them.

A second group of frames is sent with idle gaps between them. After the last frame, the four combinations of cascade and enable are applied to the held byte, which separates parity inversion from enable gating. An idle stretch at the end confirms that neither the held byte nor the strobe moves without a frame.

// File: rtl/serpar_pkg.sv
package serpar_pkg;
  // Cycles per serial bit, rounded down.
  function automatic int bit_cycles(input int clk_hz, input int baud);
    return clk_hz / baud;
  endfunction

  // Cycles in one whole frame: start + data + stop.
  function automatic int frame_cycles(input int data_w, input int bit_cyc);
    return (data_w + 2) * bit_cyc;
  endfunction
endpackage

// File: rtl/serpar_edge.sv
module serpar_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign line_s = sync_q[SYNC_STAGES-1];
  assign fall   = prev_q & ~line_s;
endmodule

// File: rtl/serpar_timing.sv
module serpar_timing #(
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  output logic busy,
  output logic sample_tick,
  output logic expire
);
  localparam int FRAME_CYC = serpar_pkg::frame_cycles(DATA_W, BIT_CYC);
  localparam int FW        = $clog2(FRAME_CYC);
  localparam int BW        = $clog2(BIT_CYC);
  localparam int IW        = $clog2(DATA_W + 3);
  localparam int HALF      = BIT_CYC / 2;

  logic [FW-1:0] frame_cnt;
  logic [BW-1:0] bit_cnt;
  logic [IW-1:0] bit_idx;
  logic          start;

  assign expire = busy && (frame_cnt == FW'(FRAME_CYC - 1));
  // A new start is accepted while idle or in the very cycle the window closes.
  assign start  = fall && (!busy || expire);
  assign sample_tick = busy && (bit_cnt == BW'(HALF - 1)) &&
                       (bit_idx >= IW'(1)) && (bit_idx <= IW'(DATA_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      frame_cnt <= '0;
      bit_cnt   <= '0;
      bit_idx   <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      frame_cnt <= '0;
      bit_cnt   <= '0;
      bit_idx   <= '0;
    end else if (busy) begin
      if (expire) busy <= 1'b0;
      frame_cnt <= frame_cnt + 1'b1;
      if (bit_cnt == BW'(BIT_CYC - 1)) begin
        bit_cnt <= '0;
        bit_idx <= bit_idx + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  AST_EXPIRE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (bit_idx == IW'(DATA_W + 1))); // R4
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire && fall) |=> (frame_cnt != '0)); // R10
endmodule

// File: rtl/serpar_shift_hold.sv
module serpar_shift_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              sample_tick,
  input  logic              expire,
  output logic [DATA_W-1:0] hold_q,
  output logic              valid_q
);
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      hold_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= expire;
      if (sample_tick) shift_q <= {line_s, shift_q[DATA_W-1:1]};
      if (expire)      hold_q  <= shift_q;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> $stable(hold_q)); // R5
endmodule

// File: rtl/serpar_parity.sv
module serpar_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              casc,
  input  logic              en,
  output logic              even,
  output logic              odd
);
  logic [DATA_W:0] folded;

  // Running XOR chain, cascade bit at the head.
  assign folded[0] = casc;
  for (genvar i = 0; i < DATA_W; i++) begin : g_fold
    assign folded[i+1] = folded[i] ^ data[i];
  end

  assign odd  = en &  folded[DATA_W];
  assign even = en & ~folded[DATA_W];

  always_comb begin
    AST_PAR_EXCLUSIVE: assert (!(even && odd)); // R7
    AST_EN_LOW_ZERO:   assert (en || (!even && !odd)); // R8
  end
endmodule

// File: rtl/serpar_parity_rx.sv
module serpar_parity_rx #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BAUD        = 9600,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              casc_in,
  input  logic              par_en,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              par_even,
  output logic              par_odd
);
  localparam int BIT_CYC = serpar_pkg::bit_cycles(CLK_HZ, BAUD);

  logic line_s, fall, busy, sample_tick, expire;

  serpar_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .line_s(line_s), .fall(fall)
  );

  serpar_timing #(.DATA_W(DATA_W), .BIT_CYC(BIT_CYC)) u_timing (
    .clk(clk), .rst_n(rst_n), .fall(fall),
    .busy(busy), .sample_tick(sample_tick), .expire(expire)
  );

  serpar_shift_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .sample_tick(sample_tick),
    .expire(expire), .hold_q(rx_byte), .valid_q(rx_valid)
  );

  serpar_parity #(.DATA_W(DATA_W)) u_par (
    .data(rx_byte), .casc(casc_in), .en(par_en),
    .even(par_even), .odd(par_odd)
  );

  AST_VALID_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(busy)); // R4
  AST_SAMPLE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> (busy && !fall)); // R3
endmodule

// File: tb/serpar_parity_rx_tb.sv
module serpar_parity_rx_tb;
  localparam int CLK_HZ = 400_000;
  localparam int BAUD   = 50_000;
  localparam int B      = CLK_HZ / BAUD;  // 8 cycles per bit
  localparam int DW     = 8;
  localparam int MAXF   = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1;
  logic casc_in = 1'b0;
  logic par_en = 1'b0;
  logic [DW-1:0] rx_byte;
  logic rx_valid, par_even, par_odd;

  int checks = 0;
  int failures = 0;
  int sent = 0;
  int got = 0;
  int cycles = 0;
  logic [DW-1:0] exp_q [MAXF];

  always #10 clk = ~clk;

  serpar_parity_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .casc_in(casc_in),
    .par_en(par_en), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .par_even(par_even), .par_odd(par_odd)
  );

  function automatic logic exp_even(input logic [DW-1:0] v, input logic c, input logic e);
    int ones = int'(c);
    for (int i = 0; i < DW; i++) ones += int'(v[i]);
    return e && (ones % 2 == 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_frame(input logic [DW-1:0] v, input logic c, input logic e);
    exp_q[sent] = v;
    sent++;
    casc_in = c;
    par_en  = e;
    line_in = 1'b0;
    wait_cyc(B);
    for (int i = 0; i < DW; i++) begin
      line_in = v[i];
      wait_cyc(B);
    end
    line_in = 1'b1;
    wait_cyc(B);
  endtask

  // Monitor: compare every strobe against the byte queue and live parity inputs.
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (got < sent) begin
        check("R2/R3/R9 byte", int'(rx_byte), int'(exp_q[got]));
        check("R6 even", int'(par_even), int'(exp_even(exp_q[got], casc_in, par_en)));
        check("R7 odd", int'(par_odd), int'(par_en && !exp_even(exp_q[got], casc_in, 1'b1)));
      end else begin
        check("R4 strobe without frame", 1, 0);
      end
      got++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150_000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] last;
    par_en = 1'b1;
    wait_cyc(5);
    // R1: reset state
    check("R1 byte in reset", int'(rx_byte), 0);
    check("R1 valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1 byte after reset", int'(rx_byte), 0);
    check("R6 even on zero byte", int'(par_even), 1);

    // R9/R10: every byte back-to-back, varying cascade and enable
    for (int v = 0; v < 256; v++)
      send_frame(DW'(v), v[2] ^ v[5], (v % 5) != 0);

    // frames separated by idle gaps
    for (int k = 0; k < 6; k++) begin
      wait_cyc(13 + 7 * k);
      send_frame(DW'(8'h5A ^ (k * 37)), k[0], 1'b1);
    end
    wait_cyc(3 * B);
    check("R4 one strobe per frame", got, sent);
    last = exp_q[sent-1];

    // R6/R7/R8: all cascade/enable combos on the held byte
    for (int c = 0; c < 2; c++) begin
      for (int e = 0; e < 2; e++) begin
        casc_in = c[0];
        par_en  = e[0];
        wait_cyc(1);
        check("R6 even sweep", int'(par_even), int'(exp_even(last, c[0], e[0])));
        check("R7 odd sweep", int'(par_odd), int'(e[0] && !exp_even(last, c[0], 1'b1)));
        if (e == 0) check("R8 enable low", int'(par_even | par_odd), 0);
      end
    end

    // R5: long idle leaves the held byte and strobe count untouched
    wait_cyc(20 * B);
    check("R5 held byte", int'(rx_byte), int'(last));
    check("R4 no idle strobe", got, sent);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule